// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

This block fetches a single instruction for a core that may accept 16-bit compressed encodings next to 32-bit base encodings. A fetch starts with a one-cycle `start_i` pulse carrying the program counter and a flag that says whether compressed encodings are enabled. The block checks the alignment of the PC first. It then walks the instruction in two 16-bit pieces. Each piece is translated on its own through an external translation port and then read through an external memory port.

A fault on the upper piece is therefore reported against PC+2 rather than PC. If the first piece turns out to be a complete compressed instruction, no second piece is fetched at all. The fetch ends with a one-cycle `done_o` strobe. Exactly one of three results is valid with it: a 16-bit instruction, a 32-bit instruction, or an exception code with the faulting virtual address.

Both external ports use the same request/response rules. A request is held on `*_req_valid_o` with a stable address until the responder raises `*_req_ready_i`, and the handshake completes in the cycle both are high. The responder may apply back-pressure for any number of cycles. The response arrives as a single-cycle `*_rsp_valid_i` pulse, at the earliest one cycle after the handshake, and may come any number of cycles later. The block never has more than one request outstanding. Control (`start_i`, `busy_o`, `done_o`) is plain level signalling.

Top module: `cfetch_unit`

## Requirements
- R1: When PC bit 0 is 1 at start, the fetch ends with exception code 0 (misaligned) and the PC as address. `done_o` rises in the cycle after start, and no translation or memory request is made.
- R2: When PC bit 1 is 1 and `c_en_i` is low at start, the fetch ends as in R1 with code 0. With `c_en_i` high, the same PC is fetched normally.
- R3: When the first halfword read at the translated PC has bits [1:0] other than 2'b11, the result is that halfword on `half_o` with `half_valid_o`. Exactly one translation and one memory request are made.
- R4: When the first halfword has bits [1:0] equal to 2'b11, address PC+2 is translated and read as a second halfword. The result on `word_o` has the second halfword in bits 31:16 and the first in bits 15:0.
- R5: A translation fault ends the fetch with the translator's code on `err_code_o`. The address is PC for the first halfword and PC+2 for the second, and no memory request is made for the faulting halfword.
- R6: A memory read error ends the fetch with code 1 (access fault). The address is PC for the first halfword and PC+2 for the second.
- R7: `done_o` lasts one cycle and comes with exactly one of `half_valid_o`, `word_valid_o`, `err_valid_o`. No result flag is high without `done_o`. `busy_o` is high from the cycle after an aligned start up to, not including, the `done_o` cycle. No request is raised while `busy_o` is low.
- R8: A raised translation or memory request stays raised, with an unchanged address, until its ready input is seen high.
- R9: `start_i` is ignored while `busy_o` is high. `c_en_i` is sampled only at start, so changing it during a fetch has no effect.
- R10: After reset, `busy_o`, `done_o`, the three result flags and both request valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a fetch (accepted only while idle) |
| c_en_i | input | 1 | compressed encodings enabled, sampled with start |
| pc_i | input | XLEN | virtual PC, sampled with start |
| busy_o | output | 1 | fetch in progress |
| done_o | output | 1 | one-cycle completion strobe |
| half_valid_o | output | 1 | result is a 16-bit instruction |
| half_o | output | 16 | 16-bit instruction |
| word_valid_o | output | 1 | result is a 32-bit instruction |
| word_o | output | 32 | 32-bit instruction |
| err_valid_o | output | 1 | result is an exception |
| err_code_o | output | ECW | exception code |
| err_addr_o | output | XLEN | faulting virtual address |
| xl_req_valid_o | output | 1 | translation request valid |
| xl_req_ready_i | input | 1 | translation request accepted |
| xl_req_vaddr_o | output | XLEN | virtual address to translate |
| xl_rsp_valid_i | input | 1 | translation response pulse |
| xl_rsp_fault_i | input | 1 | translation failed |
| xl_rsp_code_i | input | ECW | exception code on failure |
| xl_rsp_paddr_i | input | XLEN | physical address on success |
| mem_req_valid_o | output | 1 | memory read request valid |
| mem_req_ready_i | input | 1 | memory request accepted |
| mem_req_addr_o | output | XLEN | physical halfword address |
| mem_rsp_valid_i | input | 1 | memory response pulse |
| mem_rsp_err_i | input | 1 | read failed |
| mem_rsp_data_i | input | 16 | halfword read |

## Verification
The fetch is exercised with odd PCs, with PCs whose bit 1 is set under both settings of the compressed enable, and with aligned PCs whose first halfword is forced to be short or long. These patterns separate the misaligned path, the one-read compressed path and the two-read base path. Faults are injected on the translation and on the memory read of each halfword separately. This shows whether the code and the address (PC or PC+2) come from the right piece. Randomised ready and response delays on both ports, a second start and a toggled enable in mid-fetch show that the result does not depend on wait states or on stray control. Request addresses are checked on every clock against the expected halfword.

// File: rtl/cfetch_pkg.sv
package cfetch_pkg;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XREQ,
    ST_XWAIT,
    ST_MREQ,
    ST_MWAIT
  } fetch_st_e;

  typedef enum logic [1:0] {
    FIN_NONE,
    FIN_HALF,
    FIN_WORD,
    FIN_ERR
  } fin_e;
endpackage

// File: rtl/cfetch_align.sv
module cfetch_align (
  input  logic [1:0] pc_lo,
  input  logic       c_en,
  output logic       misaligned
);
  // bit 0 is never legal; bit 1 is legal only when 16-bit encodings exist
  assign misaligned = pc_lo[0] | (pc_lo[1] & ~c_en);
endmodule

// File: rtl/cfetch_seq.sv
module cfetch_seq
  import cfetch_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int ECW          = 4,
  parameter int EXC_MISALIGN = 0,
  parameter int EXC_ACCESS   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                misaligned,
  input  logic [XLEN-1:0]     pc,
  output logic                busy,
  output logic                xl_req_valid,
  input  logic                xl_req_ready,
  output logic [XLEN-1:0]     xl_req_vaddr,
  input  logic                xl_rsp_valid,
  input  logic                xl_rsp_fault,
  input  logic [ECW-1:0]      xl_rsp_code,
  input  logic [XLEN-1:0]     xl_rsp_paddr,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [XLEN-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic                mem_rsp_err,
  input  logic [HALF_W-1:0]   mem_rsp_data,
  output fin_e                fin_kind,
  output logic [ECW-1:0]      fin_code,
  output logic [XLEN-1:0]     fin_addr,
  output logic [HALF_W-1:0]   fin_half,
  output logic [2*HALF_W-1:0] fin_word
);
  localparam logic [XLEN-1:0] STEP     = XLEN'(HALF_W / 8);
  localparam logic [ECW-1:0]  CODE_MIS = ECW'(EXC_MISALIGN);
  localparam logic [ECW-1:0]  CODE_ACC = ECW'(EXC_ACCESS);

  fetch_st_e          st_q, st_d;
  logic               hi_q;
  logic [XLEN-1:0]    pc_q;
  logic [XLEN-1:0]    paddr_q;
  logic [HALF_W-1:0]  lo_q;
  logic [XLEN-1:0]    vaddr;
  logic               is_short;

  assign vaddr         = hi_q ? (pc_q + STEP) : pc_q;
  assign is_short      = (mem_rsp_data[1:0] != 2'b11);
  assign busy          = (st_q != ST_IDLE);
  assign xl_req_valid  = (st_q == ST_XREQ);
  assign xl_req_vaddr  = vaddr;
  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_addr  = paddr_q;
  assign fin_half      = mem_rsp_data;
  assign fin_word      = {mem_rsp_data, lo_q};

  always_comb begin
    st_d     = st_q;
    fin_kind = FIN_NONE;
    fin_code = '0;
    fin_addr = vaddr;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (misaligned) begin
            fin_kind = FIN_ERR;
            fin_code = CODE_MIS;
            fin_addr = pc;
          end else begin
            st_d = ST_XREQ;
          end
        end
      end
      ST_XREQ: if (xl_req_ready) st_d = ST_XWAIT;
      ST_XWAIT: begin
        if (xl_rsp_valid) begin
          if (xl_rsp_fault) begin
            fin_kind = FIN_ERR;
            fin_code = xl_rsp_code;
            st_d     = ST_IDLE;
          end else begin
            st_d = ST_MREQ;
          end
        end
      end
      ST_MREQ: if (mem_req_ready) st_d = ST_MWAIT;
      ST_MWAIT: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fin_kind = FIN_ERR;
            fin_code = CODE_ACC;
            st_d     = ST_IDLE;
          end else if (hi_q) begin
            fin_kind = FIN_WORD;
            st_d     = ST_IDLE;
          end else if (is_short) begin
            fin_kind = FIN_HALF;
            st_d     = ST_IDLE;
          end else begin
            st_d = ST_XREQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      hi_q    <= 1'b0;
      pc_q    <= '0;
      paddr_q <= '0;
      lo_q    <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start && !misaligned) begin
        pc_q <= pc;
        hi_q <= 1'b0;
      end
      if (st_q == ST_XWAIT && xl_rsp_valid && !xl_rsp_fault) begin
        paddr_q <= xl_rsp_paddr;
      end
      if (st_q == ST_MWAIT && mem_rsp_valid && !mem_rsp_err && !hi_q && !is_short) begin
        lo_q <= mem_rsp_data;
        hi_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfetch_result.sv
module cfetch_result
  import cfetch_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ECW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fin_e                fin_kind,
  input  logic [ECW-1:0]      fin_code,
  input  logic [XLEN-1:0]     fin_addr,
  input  logic [HALF_W-1:0]   fin_half,
  input  logic [2*HALF_W-1:0] fin_word,
  output logic                done,
  output logic                half_valid,
  output logic [HALF_W-1:0]   half,
  output logic                word_valid,
  output logic [2*HALF_W-1:0] word,
  output logic                err_valid,
  output logic [ECW-1:0]      err_code,
  output logic [XLEN-1:0]     err_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      half_valid <= 1'b0;
      word_valid <= 1'b0;
      err_valid  <= 1'b0;
      half       <= '0;
      word       <= '0;
      err_code   <= '0;
      err_addr   <= '0;
    end else begin
      done       <= (fin_kind != FIN_NONE);
      half_valid <= (fin_kind == FIN_HALF);
      word_valid <= (fin_kind == FIN_WORD);
      err_valid  <= (fin_kind == FIN_ERR);
      if (fin_kind == FIN_HALF) half <= fin_half;
      if (fin_kind == FIN_WORD) word <= fin_word;
      if (fin_kind == FIN_ERR) begin
        err_code <= fin_code;
        err_addr <= fin_addr;
      end
    end
  end
endmodule

// File: rtl/cfetch_unit.sv
module cfetch_unit
  import cfetch_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int ECW          = 4,
  parameter int EXC_MISALIGN = 0,
  parameter int EXC_ACCESS   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                c_en_i,
  input  logic [XLEN-1:0]     pc_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                half_valid_o,
  output logic [HALF_W-1:0]   half_o,
  output logic                word_valid_o,
  output logic [2*HALF_W-1:0] word_o,
  output logic                err_valid_o,
  output logic [ECW-1:0]      err_code_o,
  output logic [XLEN-1:0]     err_addr_o,
  output logic                xl_req_valid_o,
  input  logic                xl_req_ready_i,
  output logic [XLEN-1:0]     xl_req_vaddr_o,
  input  logic                xl_rsp_valid_i,
  input  logic                xl_rsp_fault_i,
  input  logic [ECW-1:0]      xl_rsp_code_i,
  input  logic [XLEN-1:0]     xl_rsp_paddr_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [XLEN-1:0]     mem_req_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic                mem_rsp_err_i,
  input  logic [HALF_W-1:0]   mem_rsp_data_i
);
  logic                misaligned;
  fin_e                fin_kind;
  logic [ECW-1:0]      fin_code;
  logic [XLEN-1:0]     fin_addr;
  logic [HALF_W-1:0]   fin_half;
  logic [2*HALF_W-1:0] fin_word;

  cfetch_align align_i (
    .pc_lo      (pc_i[1:0]),
    .c_en       (c_en_i),
    .misaligned (misaligned)
  );

  cfetch_seq #(
    .XLEN(XLEN), .ECW(ECW), .EXC_MISALIGN(EXC_MISALIGN), .EXC_ACCESS(EXC_ACCESS)
  ) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_i),
    .misaligned    (misaligned),
    .pc            (pc_i),
    .busy          (busy_o),
    .xl_req_valid  (xl_req_valid_o),
    .xl_req_ready  (xl_req_ready_i),
    .xl_req_vaddr  (xl_req_vaddr_o),
    .xl_rsp_valid  (xl_rsp_valid_i),
    .xl_rsp_fault  (xl_rsp_fault_i),
    .xl_rsp_code   (xl_rsp_code_i),
    .xl_rsp_paddr  (xl_rsp_paddr_i),
    .mem_req_valid (mem_req_valid_o),
    .mem_req_ready (mem_req_ready_i),
    .mem_req_addr  (mem_req_addr_o),
    .mem_rsp_valid (mem_rsp_valid_i),
    .mem_rsp_err   (mem_rsp_err_i),
    .mem_rsp_data  (mem_rsp_data_i),
    .fin_kind      (fin_kind),
    .fin_code      (fin_code),
    .fin_addr      (fin_addr),
    .fin_half      (fin_half),
    .fin_word      (fin_word)
  );

  cfetch_result #(.XLEN(XLEN), .ECW(ECW)) result_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin_kind   (fin_kind),
    .fin_code   (fin_code),
    .fin_addr   (fin_addr),
    .fin_half   (fin_half),
    .fin_word   (fin_word),
    .done       (done_o),
    .half_valid (half_valid_o),
    .half       (half_o),
    .word_valid (word_valid_o),
    .word       (word_o),
    .err_valid  (err_valid_o),
    .err_code   (err_code_o),
    .err_addr   (err_addr_o)
  );
endmodule

// File: rtl/cfetch_unit_chk.sv
module cfetch_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic            half_valid_o,
  input logic [15:0]     half_o,
  input logic            word_valid_o,
  input logic [31:0]     word_o,
  input logic            err_valid_o,
  input logic            xl_req_valid_o,
  input logic            xl_req_ready_i,
  input logic [XLEN-1:0] xl_req_vaddr_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [XLEN-1:0] mem_req_addr_o
);
  // R8: translation request holds with its address until accepted
  a_r8_xl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req_valid_o && !xl_req_ready_i) |=> (xl_req_valid_o && $stable(xl_req_vaddr_o)));

  // R8: memory request holds with its address until accepted
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R7: exactly one result kind with done, none without
  a_r7_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot({half_valid_o, word_valid_o, err_valid_o}));

  a_r7_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ({half_valid_o, word_valid_o, err_valid_o} == 3'b000));

  // R7: completion strobe never overlaps busy
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7: no port traffic while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!xl_req_valid_o && !mem_req_valid_o));

  // R3: a 16-bit result never carries the long-form marker
  a_r3_half_is_short: assert property (@(posedge clk) disable iff (!rst_n)
    half_valid_o |-> (half_o[1:0] != 2'b11));

  // R4: a 32-bit result always carries the long-form marker in its low half
  a_r4_word_is_long: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (word_o[1:0] == 2'b11));
endmodule

bind cfetch_unit cfetch_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .half_valid_o    (half_valid_o),
  .half_o          (half_o),
  .word_valid_o    (word_valid_o),
  .word_o          (word_o),
  .err_valid_o     (err_valid_o),
  .xl_req_valid_o  (xl_req_valid_o),
  .xl_req_ready_i  (xl_req_ready_i),
  .xl_req_vaddr_o  (xl_req_vaddr_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/cfetch_unit_tb_top.sv
`timescale 1ns/1ps
module cfetch_unit_tb_top;
  localparam int XLEN = 32;
  localparam int ECW  = 4;
  localparam logic [31:0] OFF     = 32'h4000_0000;
  localparam logic [31:0] NO_ADDR = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        c_en_i = 1'b1;
  logic [31:0] pc_i = '0;
  logic        busy_o, done_o, half_valid_o, word_valid_o, err_valid_o;
  logic [15:0] half_o;
  logic [31:0] word_o;
  logic [3:0]  err_code_o;
  logic [31:0] err_addr_o;
  logic        xl_req_valid_o;
  logic        xl_req_ready_i = 1'b0;
  logic [31:0] xl_req_vaddr_o;
  logic        xl_rsp_valid_i = 1'b0;
  logic        xl_rsp_fault_i = 1'b0;
  logic [3:0]  xl_rsp_code_i = '0;
  logic [31:0] xl_rsp_paddr_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_err_i = 1'b0;
  logic [15:0] mem_rsp_data_i = '0;

  always #5 clk = ~clk;

  cfetch_unit #(.XLEN(XLEN), .ECW(ECW)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // environment settings
  logic [31:0] tf_addr = NO_ADDR;
  logic [3:0]  tf_code = 4'hC;
  logic [31:0] me_addr = NO_ADDR;
  bit          force_c = 0;
  logic [15:0] lfsr = 16'hACE1;

  // observation state
  bit          op_active = 0;
  logic [31:0] cur_pc = '0;
  int          xl_hs = 0;
  int          mem_hs = 0;
  bit          xl_pend = 0, mem_pend = 0;
  int          xl_wait = 0, mem_wait = 0;
  logic [31:0] xl_pend_addr = '0, mem_pend_addr = '0;

  function automatic logic [15:0] mem_data(logic [31:0] a, bit c);
    logic [15:0] d;
    d = a[17:2] ^ 16'hA5C3;
    d[1:0] = c ? 2'b10 : 2'b11;
    return d;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // handshake sampling
  always @(posedge clk) begin
    if (rst_n) begin
      if (xl_req_valid_o && xl_req_ready_i) begin
        xl_hs++;
        xl_pend = 1;
        xl_pend_addr = xl_req_vaddr_o;
        xl_wait = int'(lfsr[3:2]);
      end
      if (mem_req_valid_o && mem_req_ready_i) begin
        mem_hs++;
        mem_pend = 1;
        mem_pend_addr = mem_req_addr_o;
        mem_wait = int'(lfsr[5:4]);
      end
    end
  end

  // responders
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    xl_req_ready_i  = lfsr[0] | lfsr[7];
    mem_req_ready_i = lfsr[1] | lfsr[8];
    xl_rsp_valid_i  = 1'b0;
    mem_rsp_valid_i = 1'b0;
    if (xl_pend) begin
      if (xl_wait == 0) begin
        xl_pend = 0;
        xl_rsp_valid_i = 1'b1;
        xl_rsp_fault_i = (xl_pend_addr == tf_addr);
        xl_rsp_code_i  = tf_code;
        xl_rsp_paddr_i = xl_pend_addr + OFF;
      end else xl_wait--;
    end
    if (mem_pend) begin
      if (mem_wait == 0) begin
        mem_pend = 0;
        mem_rsp_valid_i = 1'b1;
        mem_rsp_err_i   = (mem_pend_addr == me_addr);
        mem_rsp_data_i  = mem_data(mem_pend_addr, force_c);
      end else mem_wait--;
    end
  end

  // one clock step with per-clock comparison against the model
  task automatic tick();
    @(negedge clk);
    if (!op_active) begin
      chk(!busy_o && !done_o, "R7", "idle busy/done", {30'd0, busy_o, done_o}, 32'd0);
      chk(!xl_req_valid_o && !mem_req_valid_o, "R7", "idle requests",
          {30'd0, xl_req_valid_o, mem_req_valid_o}, 32'd0);
    end else begin
      if (xl_req_valid_o)
        chk(xl_req_vaddr_o == ((xl_hs == 0) ? cur_pc : cur_pc + 32'd2), "R4",
            "translation vaddr", xl_req_vaddr_o, (xl_hs == 0) ? cur_pc : cur_pc + 32'd2);
      if (mem_req_valid_o)
        chk(mem_req_addr_o == ((mem_hs == 0) ? cur_pc : cur_pc + 32'd2) + OFF, "R4",
            "memory addr", mem_req_addr_o, ((mem_hs == 0) ? cur_pc : cur_pc + 32'd2) + OFF);
    end
  endtask

  // one fetch: expected outcome computed from the requirements
  task automatic run_fetch(string req, logic [31:0] pc, bit cen, bit fc,
                           logic [31:0] tfa, logic [31:0] mea, bit disturb);
    int    e_kind;   // 1 half, 2 word, 3 err
    int    e_xl, e_mem;
    logic [3:0]  e_code;
    logic [31:0] e_addr;
    logic [15:0] e_half;
    logic [31:0] e_word;
    bit    e_mis;
    int    n;
    logic [31:0] p2;
    e_code = '0; e_addr = '0; e_half = '0; e_word = '0;
    e_mis = pc[0] | (pc[1] & !cen);
    p2 = pc + 32'd2;
    if (e_mis) begin
      e_kind = 3; e_code = 4'd0; e_addr = pc; e_xl = 0; e_mem = 0;
    end else if (pc == tfa) begin
      e_kind = 3; e_code = tf_code; e_addr = pc; e_xl = 1; e_mem = 0;
    end else if (pc + OFF == mea) begin
      e_kind = 3; e_code = 4'd1; e_addr = pc; e_xl = 1; e_mem = 1;
    end else if (fc) begin
      e_kind = 1; e_half = mem_data(pc + OFF, 1'b1); e_xl = 1; e_mem = 1;
    end else if (p2 == tfa) begin
      e_kind = 3; e_code = tf_code; e_addr = p2; e_xl = 2; e_mem = 1;
    end else if (p2 + OFF == mea) begin
      e_kind = 3; e_code = 4'd1; e_addr = p2; e_xl = 2; e_mem = 2;
    end else begin
      e_kind = 2; e_word = {mem_data(p2 + OFF, 1'b0), mem_data(pc + OFF, 1'b0)};
      e_xl = 2; e_mem = 2;
    end
    tf_addr = tfa; me_addr = mea; force_c = fc;
    start_i = 1'b1; pc_i = pc; c_en_i = cen;
    cur_pc = pc; xl_hs = 0; mem_hs = 0;
    op_active = 1;
    tick();
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 200) begin
      chk(busy_o == !e_mis, "R7", "busy during fetch", {31'd0, busy_o}, {31'd0, !e_mis});
      if (disturb && n == 1) begin
        start_i = 1'b1; pc_i = 32'hDEAD_0001; c_en_i = ~cen;   // R9 stray start, enable flip
      end else start_i = 1'b0;
      tick();
      n++;
    end
    start_i = 1'b0;
    chk(done_o, req, "done seen", {31'd0, done_o}, 32'd1);
    if (e_mis) chk(n == 0, "R1", "misaligned done latency", n, 0);
    chk(!busy_o, "R7", "busy low with done", {31'd0, busy_o}, 32'd0);
    chk({half_valid_o, word_valid_o, err_valid_o} ==
        {e_kind == 1, e_kind == 2, e_kind == 3}, req, "result kind",
        {29'd0, half_valid_o, word_valid_o, err_valid_o},
        {29'd0, e_kind == 1, e_kind == 2, e_kind == 3});
    if (e_kind == 1) chk(half_o == e_half, req, "half", {16'd0, half_o}, {16'd0, e_half});
    if (e_kind == 2) chk(word_o == e_word, req, "word", word_o, e_word);
    if (e_kind == 3) begin
      chk(err_code_o == e_code, req, "err code", {28'd0, err_code_o}, {28'd0, e_code});
      chk(err_addr_o == e_addr, req, "err addr", err_addr_o, e_addr);
    end
    chk(xl_hs == e_xl, req, "translation count", xl_hs, e_xl);
    chk(mem_hs == e_mem, req, "memory count", mem_hs, e_mem);
    op_active = 0;
    tick();
    chk(!done_o, "R7", "done one cycle", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, half_valid_o, word_valid_o, err_valid_o,
         xl_req_valid_o, mem_req_valid_o} == 7'd0, "R10", "reset state",
        {25'd0, busy_o, done_o, half_valid_o, word_valid_o, err_valid_o,
         xl_req_valid_o, mem_req_valid_o}, 32'd0);
    rst_n = 1'b1;
    tick();
    chk({busy_o, done_o, xl_req_valid_o, mem_req_valid_o} == 4'd0, "R10",
        "after reset release", {28'd0, busy_o, done_o, xl_req_valid_o, mem_req_valid_o}, 32'd0);

    run_fetch("R1", 32'h0000_1001, 1'b1, 1'b0, NO_ADDR, NO_ADDR, 0);
    run_fetch("R1", 32'h0000_2003, 1'b0, 1'b1, NO_ADDR, NO_ADDR, 0);
    run_fetch("R2", 32'h0000_1002, 1'b0, 1'b1, NO_ADDR, NO_ADDR, 0);
    run_fetch("R2", 32'h0000_1002, 1'b1, 1'b1, NO_ADDR, NO_ADDR, 0);
    run_fetch("R2", 32'h0000_1006, 1'b1, 1'b0, NO_ADDR, NO_ADDR, 0);
    run_fetch("R3", 32'h0000_2000, 1'b1, 1'b1, NO_ADDR, NO_ADDR, 0);
    run_fetch("R3", 32'h0000_2000, 1'b0, 1'b1, NO_ADDR, NO_ADDR, 0);
    run_fetch("R4", 32'h0000_2000, 1'b1, 1'b0, NO_ADDR, NO_ADDR, 0);
    run_fetch("R4", 32'h0000_2FFC, 1'b0, 1'b0, NO_ADDR, NO_ADDR, 0);
    run_fetch("R5", 32'h0000_3000, 1'b1, 1'b0, 32'h0000_3000, NO_ADDR, 0);
    run_fetch("R5", 32'h0000_3000, 1'b1, 1'b0, 32'h0000_3002, NO_ADDR, 0);
    tf_code = 4'hD;
    run_fetch("R5", 32'h0000_3FFE, 1'b1, 1'b0, 32'h0000_4000, NO_ADDR, 0);
    run_fetch("R6", 32'h0000_5000, 1'b1, 1'b1, NO_ADDR, 32'h0000_5000 + OFF, 0);
    run_fetch("R6", 32'h0000_5000, 1'b1, 1'b0, NO_ADDR, 32'h0000_5002 + OFF, 0);
    run_fetch("R6", 32'h0000_5004, 1'b1, 1'b0, NO_ADDR, 32'h0000_5004 + OFF, 0);
    run_fetch("R9", 32'h0000_6002, 1'b1, 1'b0, NO_ADDR, NO_ADDR, 1);
    run_fetch("R9", 32'h0000_6004, 1'b0, 1'b1, NO_ADDR, NO_ADDR, 1);
    for (int i = 0; i < 24; i++) begin
      run_fetch("R8", 32'h0010_0000 + 32'(i * 6), 1'b1, i[0], NO_ADDR, NO_ADDR, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule